// File: doc/BRIEF.md
# Byte-Coded Channel Flag Clear Registers

This block keeps two per-channel flag vectors for a multi-channel DMA controller. One vector holds the error-interrupt enable of each channel. The other holds the pending interrupt request of each channel. A DMA engine raises request bits with one-cycle hardware set pulses. Software raises enable bits through a set input.

Software takes bits down through two write-only byte registers on a simple byte-addressed register bus. A byte written to a clear register is read as a channel number, not as a bitmask. A small number clears the flag of that one channel. A value with the global bit set empties the whole vector. Clearing an enable bit turns off the error interrupt of that channel. Clearing a request bit withdraws the interrupt request of that channel.

The register bus uses plain strobes and has no back-pressure: every write is taken in the cycle its strobe is high. A read completes in the same cycle and always returns zero. A `NUM_CH` parameter of 32 gives the narrow build, in which channel numbers 32 to 63 are reserved.

Top module: `chflag_clear_regs`

## Requirements
- R1: After reset, both `err_en` and `irq_req` are all zeros.
- R2: A write of a byte with bit 6 clear to a clear register clears only the flag of channel `wdata[5:0]` in the targeted vector. The change shows on the clock edge that samples the write strobe. The other flags of that vector keep their values.
- R3: A write of a byte with bit 6 set to a clear register clears every bit of the targeted vector on the clock edge that samples the write strobe.
- R4: Offset 0x1B targets only `err_en` and offset 0x1C targets only `irq_req`. A write to either offset leaves the other vector unchanged.
- R5: `bus_rdata` is zero on every read, whatever has been written before.
- R6: Bit 7 of the written byte is ignored. Bytes that differ only in bit 7 have the same effect.
- R7: A write to any offset other than 0x1B and 0x1C changes neither vector.
- R8: When `NUM_CH` is 32, a write of a value from 32 to 63 (bit 6 clear, bit 5 set) changes no flag.
- R9: When a hardware set pulse on `irq_set` and a clear of the same request bit happen in the same cycle, the bit ends up set. This holds for both a single-channel clear and a global clear.
- R10: A set input bit (`err_en_set` or `irq_set`) high in one cycle makes the matching flag 1 after the next clock edge. For enables, a set also wins over a clear in the same cycle.
- R11: While `bus_wr` is low, `bus_wdata` and `bus_addr` have no effect on either vector.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | ADDR_W | Byte offset within the block |
| bus_wr | input | 1 | Write strobe, one transfer per high cycle |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 8 | Write byte: bit 7 ignored, bit 6 global, bits 5:0 channel |
| bus_rdata | output | 8 | Read data, always zero |
| err_en_set | input | NUM_CH | Software set of error-interrupt enable bits |
| irq_set | input | NUM_CH | Hardware set pulses for request bits |
| err_en | output | NUM_CH | Error-interrupt enable vector |
| irq_req | output | NUM_CH | Interrupt request vector |

## Verification
Every byte value from 0 to 255 is written to each clear register while both vectors are full. This is done on a 64-channel and a 32-channel build at the same time. The sweep covers single-channel clears, global clears, reserved narrow-build values and the ignored top bit. Because each vector starts full, any cleared bit shows up, so the sweep can tell a wrong channel, a wrong vector or an extra cleared bit apart from a correct result. A sweep of all other offsets, and writes with the strobe low, show that nothing else clears a flag. Set and clear are also applied to the same bit in the same cycle to show that the set wins, and reads are checked to return zero after writes.

// File: rtl/chclr_pkg.sv
package chclr_pkg;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned IDX_W  = 6;

  // register offsets decoded by the block
  localparam logic [7:0] OFS_ERR_EN_CLR = 8'h1B;
  localparam logic [7:0] OFS_IRQ_CLR    = 8'h1C;

  typedef enum logic [1:0] {
    TGT_NONE   = 2'd0,
    TGT_ERR_EN = 2'd1,
    TGT_IRQ    = 2'd2
  } clr_tgt_e;

  typedef struct packed {
    clr_tgt_e         tgt;
    logic             all;
    logic [IDX_W-1:0] idx;
  } clr_cmd_t;
endpackage

// File: rtl/chclr_cmd_decode.sv
module chclr_cmd_decode
  import chclr_pkg::*;
#(
  parameter int unsigned ADDR_W = 8
) (
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [BYTE_W-1:0] wdata,
  output clr_cmd_t          cmd
);
  localparam logic [ADDR_W-1:0] ERR_OFS = ADDR_W'(OFS_ERR_EN_CLR);
  localparam logic [ADDR_W-1:0] IRQ_OFS = ADDR_W'(OFS_IRQ_CLR);

  // the most significant byte bit is reserved and takes no part in decode
  logic unused_rsvd_bit;
  assign unused_rsvd_bit = wdata[BYTE_W-1];

  always_comb begin
    cmd.tgt = TGT_NONE;
    if (wr) begin
      if (addr == ERR_OFS)      cmd.tgt = TGT_ERR_EN;
      else if (addr == IRQ_OFS) cmd.tgt = TGT_IRQ;
    end
    cmd.all = wdata[IDX_W];
    cmd.idx = wdata[IDX_W-1:0];
  end
endmodule

// File: rtl/chclr_mask_gen.sv
module chclr_mask_gen
  import chclr_pkg::*;
#(
  parameter int unsigned NUM_CH = 64,
  parameter clr_tgt_e    TARGET = TGT_IRQ
) (
  input  clr_cmd_t          cmd,
  output logic [NUM_CH-1:0] mask
);
  logic hit;
  assign hit = (cmd.tgt == TARGET);

  // an index with no matching channel (reserved in narrow builds) selects nothing
  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
    assign mask[ch] = hit && (cmd.all || (cmd.idx == IDX_W'(ch)));
  end
endmodule

// File: rtl/chclr_flag_bank.sv
module chclr_flag_bank #(
  parameter int unsigned NUM_CH = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] set,
  input  logic [NUM_CH-1:0] clr,
  output logic [NUM_CH-1:0] q
);
  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           q[ch] <= 1'b0;
      else if (set[ch])     q[ch] <= 1'b1;   // a set beats a clear
      else if (clr[ch])     q[ch] <= 1'b0;
    end
  end
endmodule

// File: rtl/chflag_clear_regs.sv
module chflag_clear_regs
  import chclr_pkg::*;
#(
  parameter int unsigned NUM_CH = 64,
  parameter int unsigned ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  input  logic [NUM_CH-1:0] err_en_set,
  input  logic [NUM_CH-1:0] irq_set,
  output logic [NUM_CH-1:0] err_en,
  output logic [NUM_CH-1:0] irq_req
);
  clr_cmd_t          cmd;
  logic [NUM_CH-1:0] err_clr;
  logic [NUM_CH-1:0] irq_clr;

  // both clear registers are write-only; reads see zero
  logic unused_rd_strobe;
  assign unused_rd_strobe = bus_rd;
  assign bus_rdata = '0;

  chclr_cmd_decode #(.ADDR_W(ADDR_W)) u_dec (
    .wr   (bus_wr),
    .addr (bus_addr),
    .wdata(bus_wdata),
    .cmd  (cmd)
  );

  chclr_mask_gen #(.NUM_CH(NUM_CH), .TARGET(TGT_ERR_EN)) u_err_mask (
    .cmd (cmd),
    .mask(err_clr)
  );

  chclr_mask_gen #(.NUM_CH(NUM_CH), .TARGET(TGT_IRQ)) u_irq_mask (
    .cmd (cmd),
    .mask(irq_clr)
  );

  chclr_flag_bank #(.NUM_CH(NUM_CH)) u_err_bank (
    .clk  (clk),
    .rst_n(rst_n),
    .set  (err_en_set),
    .clr  (err_clr),
    .q    (err_en)
  );

  chclr_flag_bank #(.NUM_CH(NUM_CH)) u_irq_bank (
    .clk  (clk),
    .rst_n(rst_n),
    .set  (irq_set),
    .clr  (irq_clr),
    .q    (irq_req)
  );
endmodule

// File: rtl/chflag_clear_regs_chk.sv
module chflag_clear_regs_chk #(
  parameter int unsigned NUM_CH = 64,
  parameter int unsigned ADDR_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_wr,
  input logic [7:0]        bus_wdata,
  input logic [NUM_CH-1:0] err_en_set,
  input logic [NUM_CH-1:0] irq_set,
  input logic [NUM_CH-1:0] err_en,
  input logic [NUM_CH-1:0] irq_req
);
  localparam logic [ADDR_W-1:0] ERR_A = ADDR_W'(8'h1B);
  localparam logic [ADDR_W-1:0] IRQ_A = ADDR_W'(8'h1C);

  logic unused_b7;
  assign unused_b7 = bus_wdata[7];

  logic              w_err, w_irq, w_other;
  logic [NUM_CH-1:0] sel;
  assign w_err   = bus_wr && (bus_addr == ERR_A);
  assign w_irq   = bus_wr && (bus_addr == IRQ_A);
  assign w_other = bus_wr && !w_err && !w_irq;
  assign sel     = NUM_CH'(64'd1 << bus_wdata[5:0]);

  assert_global_irq_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (w_irq && bus_wdata[6] && irq_set == '0) |=> (irq_req == '0));

  assert_global_err_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (w_err && bus_wdata[6] && err_en_set == '0) |=> (err_en == '0));

  assert_single_irq_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (w_irq && !bus_wdata[6]) |=> (($past(irq_req) & ~irq_req & ~$past(sel)) == '0));

  assert_single_err_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (w_err && !bus_wdata[6]) |=> (($past(err_en) & ~err_en & ~$past(sel)) == '0));

  assert_irq_reg_keeps_err_R4: assert property (@(posedge clk) disable iff (!rst_n)
    w_irq |=> (($past(err_en) & ~err_en) == '0));

  assert_err_reg_keeps_irq_R4: assert property (@(posedge clk) disable iff (!rst_n)
    w_err |=> (($past(irq_req) & ~irq_req) == '0));

  assert_other_ofs_R7: assert property (@(posedge clk) disable iff (!rst_n)
    w_other |=> ((($past(irq_req) & ~irq_req) == '0) && (($past(err_en) & ~err_en) == '0)));

  assert_idle_bus_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_wr |=> ((($past(irq_req) & ~irq_req) == '0) && (($past(err_en) & ~err_en) == '0)));

  assert_irq_set_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_set != '0) |=> ((irq_req & $past(irq_set)) == $past(irq_set)));

  assert_err_set_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (err_en_set != '0) |=> ((err_en & $past(err_en_set)) == $past(err_en_set)));

  if (NUM_CH < 64) begin : g_narrow
    assert_reserved_idx_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && !bus_wdata[6] && (bus_wdata[5:0] >= 6'(NUM_CH)))
        |=> ((($past(irq_req) & ~irq_req) == '0) && (($past(err_en) & ~err_en) == '0)));
  end
endmodule

bind chflag_clear_regs chflag_clear_regs_chk #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_addr  (bus_addr),
  .bus_wr    (bus_wr),
  .bus_wdata (bus_wdata),
  .err_en_set(err_en_set),
  .irq_set   (irq_set),
  .err_en    (err_en),
  .irq_req   (irq_req)
);

// File: tb/chflag_clear_regs_test.sv
module chflag_clear_regs_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  addr = '0;
  logic        wr = 1'b0;
  logic        rd = 1'b0;
  logic [7:0]  wdata = '0;
  logic [63:0] eset = '0;
  logic [63:0] iset = '0;
  logic [63:0] err64, irq64;
  logic [31:0] err32, irq32;
  logic [7:0]  rd64, rd32;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  chflag_clear_regs #(.NUM_CH(64)) uut (
    .clk(clk), .rst_n(rst_n), .bus_addr(addr), .bus_wr(wr), .bus_rd(rd),
    .bus_wdata(wdata), .bus_rdata(rd64), .err_en_set(eset), .irq_set(iset),
    .err_en(err64), .irq_req(irq64)
  );

  chflag_clear_regs #(.NUM_CH(32)) uut32 (
    .clk(clk), .rst_n(rst_n), .bus_addr(addr), .bus_wr(wr), .bus_rd(rd),
    .bus_wdata(wdata), .bus_rdata(rd32), .err_en_set(eset[31:0]), .irq_set(iset[31:0]),
    .err_en(err32), .irq_req(irq32)
  );

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cmp(input string tag, input logic [63:0] act, input logic [63:0] exp);
    chk(act === exp, tag, act, exp);
  endtask

  function automatic logic [63:0] full(input int n);
    return (n == 64) ? '1 : {32'd0, 32'hFFFF_FFFF};
  endfunction

  // expected target vector after a clear of a full vector with value v
  function automatic logic [63:0] after_clr(input int n, input logic [6:0] v);
    if (v[6]) return '0;
    if (int'(v[5:0]) < n) return full(n) & ~(64'd1 << v[5:0]);
    return full(n);
  endfunction

  // fill both vectors, then issue one cycle with the given bus and set values
  task automatic fill_then(input logic w, input logic [7:0] a, input logic [7:0] d,
                           input logic [63:0] es, input logic [63:0] is);
    @(negedge clk);
    eset = '1; iset = '1; wr = 1'b0;
    @(negedge clk);
    eset = es; iset = is; wr = w; addr = a; wdata = d;
    @(negedge clk);
    eset = '0; iset = '0; wr = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    cmp("R1 reset err64", err64, '0);
    cmp("R1 reset irq64", irq64, '0);
    cmp("R1 reset err32", {32'd0, err32}, '0);
    cmp("R1 reset irq32", {32'd0, irq32}, '0);

    // R10: one set pulse raises one bit
    eset = 64'h1 << 37; iset = 64'h1 << 5;
    @(negedge clk);
    eset = '0; iset = '0;
    cmp("R10 err set", err64, 64'h1 << 37);
    cmp("R10 irq set", irq64, 64'h1 << 5);
    cmp("R10 irq32 set", {32'd0, irq32}, 64'h20);

    // R2 R3 R4 R6 R8: every byte to each clear register
    for (int t = 0; t < 2; t++) begin
      for (int b = 0; b < 256; b++) begin
        logic [7:0] a;
        a = (t == 0) ? 8'h1B : 8'h1C;
        fill_then(1'b1, a, 8'(b), '0, '0);
        if (t == 0) begin
          cmp($sformatf("R2/R3/R6 err64 byte %0d", b), err64, after_clr(64, 7'(b)));
          cmp($sformatf("R4 irq64 kept byte %0d", b), irq64, full(64));
          cmp($sformatf("R8/R2 err32 byte %0d", b), {32'd0, err32}, after_clr(32, 7'(b)));
          cmp($sformatf("R4 irq32 kept byte %0d", b), {32'd0, irq32}, full(32));
        end else begin
          cmp($sformatf("R2/R3/R6 irq64 byte %0d", b), irq64, after_clr(64, 7'(b)));
          cmp($sformatf("R4 err64 kept byte %0d", b), err64, full(64));
          cmp($sformatf("R8/R2 irq32 byte %0d", b), {32'd0, irq32}, after_clr(32, 7'(b)));
          cmp($sformatf("R4 err32 kept byte %0d", b), {32'd0, err32}, full(32));
        end
      end
    end

    // R7: global clear byte to every other offset
    for (int a = 0; a < 256; a++) begin
      if (a == 8'h1B || a == 8'h1C) continue;
      fill_then(1'b1, 8'(a), 8'h40, '0, '0);
      cmp($sformatf("R7 err64 ofs %0d", a), err64, full(64));
      cmp($sformatf("R7 irq64 ofs %0d", a), irq64, full(64));
    end

    // R11: strobe low with a global clear on the data lines
    fill_then(1'b0, 8'h1C, 8'h40, '0, '0);
    cmp("R11 irq64 idle", irq64, full(64));
    fill_then(1'b0, 8'h1B, 8'h40, '0, '0);
    cmp("R11 err64 idle", err64, full(64));

    // R9: set and clear of the same request bit in one cycle
    fill_then(1'b1, 8'h1C, 8'd9, '0, 64'h1 << 9);
    cmp("R9 irq single clear vs set", irq64, full(64));
    fill_then(1'b1, 8'h1C, 8'h40, '0, 64'h1 << 63);
    cmp("R9 irq global clear vs set", irq64, 64'h1 << 63);
    cmp("R9 irq32 global clear vs set", {32'd0, irq32}, 64'h0);
    fill_then(1'b1, 8'h1C, 8'h40, '0, 64'h1 << 17);
    cmp("R9 irq32 global clear vs set bit17", {32'd0, irq32}, 64'h1 << 17);

    // R10: enable set wins over a clear
    fill_then(1'b1, 8'h1B, 8'h40, 64'h1 << 2, '0);
    cmp("R10 err set vs global clear", err64, 64'h4);

    // R5: reads return zero after writes
    @(negedge clk);
    rd = 1'b1; addr = 8'h1B;
    #1;
    cmp("R5 read err reg 64", {56'd0, rd64}, '0);
    cmp("R5 read err reg 32", {56'd0, rd32}, '0);
    addr = 8'h1C;
    #1;
    cmp("R5 read irq reg 64", {56'd0, rd64}, '0);
    @(negedge clk);
    rd = 1'b0;

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=running expected=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule